// File: doc/BRIEF.md
# Translation Buffer with Page-Table Walker

This block translates 32-bit virtual byte addresses into 30-bit physical byte addresses for 4 KB pages. A small, fully associative store of recent page mappings answers most requests. When a request hits, the physical address is returned on the cycle after the request is accepted, and the block makes no memory access. When it misses, a built-in walker fetches one 32-bit page-table entry over a plain request/response memory port. The entry is read from the address `base + 4*VPN`, where `base` is a programmable table-base register. The walker then either installs the mapping, replacing the least recently used slot, or reports a page fault.

A requester presents an address and a read/write flag with a valid/ready handshake. Only one translation is in flight at a time. The block also keeps each page's modified flag up to date: the first store to a page whose flag is clear causes the block to write the updated entry back to the page table before it answers. A flush input, and any load of the base register, invalidate every cached mapping at once.

Top module: `xlat_tlb`

## Requirements
- R1: A request whose virtual page number (vaddr bits 31:12) is cached, and which is either a read or a write to a page already marked modified, produces a response one clock after acceptance with rsp_hit=1, rsp_fault=0 and rsp_paddr = {cached PPN, vaddr[11:0]}, and makes no memory access.
- R2: A request whose page is not cached issues exactly one memory read at byte address (base + 4*VPN) truncated to 30 bits, and then responds with rsp_hit=0.
- R3: A page-table entry is decoded as bit 31 = present, bit 30 = modified and bits 17:0 = physical page number; the rest are zero. After a successful walk, rsp_paddr = {entry[17:0], vaddr[11:0]}.
- R4: If a fetched entry has bit 31 clear, the response has rsp_fault=1 and rsp_hit=0. Nothing is installed and replacement order is unchanged, so the same page misses again on its next request.
- R5: A write to a page whose modified flag is clear, whether cached or just fetched, issues exactly one memory write to that page's entry address before the response. The write data is {1'b1, 1'b1, 12'b0, PPN}. Later writes to the same cached page cause no memory write.
- R6: Empty slots are filled before any mapping is evicted. When every slot is full, a fill replaces the mapping that was least recently hit or filled.
- R7: req_ready is low from acceptance until the response for any request that needs a memory access. Each accepted request yields exactly one single-cycle rsp_valid pulse.
- R8: A one-cycle pulse on flush invalidates every cached mapping, so each page's next request misses.
- R9: A load of the base register (ptbr_we) takes effect for later walks and also invalidates every cached mapping.
- R10: After reset, req_ready=1, rsp_valid=0, mem_req_valid=0 and the translation store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual byte address |
| req_write | input | 1 | Request is a store |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 30 | Physical byte address |
| rsp_hit | output | 1 | Translation came from the cached store |
| rsp_fault | output | 1 | Page not present |
| flush | input | 1 | Invalidate all cached mappings |
| ptbr_we | input | 1 | Load the page-table base register |
| ptbr_wdata | input | 30 | New page-table base byte address |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 30 | Entry byte address |
| mem_req_wdata | output | 32 | Entry write data |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_rdata | input | 32 | Fetched page-table entry |

## Verification
The bench first walks page numbers in ascending order, with more pages than there are slots. This separates filling empty slots from evicting occupied ones, and a page pattern built in every fifth entry tells faults apart from fills. A second ascending pass, and then a long pseudo-random mix of reads and writes over twice as many pages as slots, tell least-recently-used replacement apart from any other victim choice. They also separate the case where a write-back is needed from the case where the page is already marked modified. Flush and base-register reloads are followed by the same page sequence, so a stale mapping shows up as a hit with a wrong address.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int VA_W_DEF   = 32;
   localparam int PA_W_DEF   = 30;
   localparam int PAGE_B_DEF = 12;
   localparam int PTE_W_DEF  = 32;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WAIT  = 2'd2,
      ST_WBACK = 2'd3
   } walk_st_e;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
   parameter int N     = 8,
   parameter int VPN_W = 20,
   parameter int PPN_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [$clog2(N)-1:0] lk_idx,
   output logic [PPN_W-1:0] lk_ppn,
   output logic             lk_dirty,
   input  logic             fill_en,
   input  logic [$clog2(N)-1:0] fill_idx,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_dirty,
   input  logic             mark_en,
   input  logic [$clog2(N)-1:0] mark_idx,
   output logic             free_ok,
   output logic [$clog2(N)-1:0] free_idx
);
   localparam int IW = $clog2(N);

   logic [N-1:0]     v_q;
   logic [N-1:0]     d_q;
   logic [VPN_W-1:0] tag_q [N];
   logic [PPN_W-1:0] ppn_q [N];
   logic [N-1:0]     match;

   for (genvar g = 0; g < N; g++) begin : g_match
      assign match[g] = v_q[g] && (tag_q[g] == lk_vpn);
   end

   always_comb begin
      lk_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match[i]) lk_idx = IW'(i);
      end
      lk_hit   = |match;
      lk_ppn   = ppn_q[lk_idx];
      lk_dirty = d_q[lk_idx];
   end

   always_comb begin
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!v_q[i]) free_idx = IW'(i);
      end
      free_ok = ~&v_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
      end else begin
         if (clr)     v_q <= '0;
         if (fill_en) v_q[fill_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[fill_idx] <= fill_vpn;
         ppn_q[fill_idx] <= fill_ppn;
         d_q[fill_idx]   <= fill_dirty;
      end
      if (mark_en) d_q[mark_idx] <= 1'b1;
   end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
   parameter int N = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 touch_en,
   input  logic [$clog2(N)-1:0] touch_idx,
   output logic [$clog2(N)-1:0] victim_idx
);
   localparam int IW = $clog2(N);

   logic [IW-1:0] age_q [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
      end else if (touch_en) begin
         for (int i = 0; i < N; i++) begin
            if (IW'(i) == touch_idx)                 age_q[i] <= '0;
            else if (age_q[i] < age_q[touch_idx])    age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      victim_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (age_q[i] == IW'(N - 1)) victim_idx = IW'(i);
      end
   end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VA_W    = VA_W_DEF,
   parameter int PA_W    = PA_W_DEF,
   parameter int PAGE_B  = PAGE_B_DEF,
   parameter int PTE_W   = PTE_W_DEF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic            req_write,
   output logic            rsp_valid,
   output logic [PA_W-1:0] rsp_paddr,
   output logic            rsp_hit,
   output logic            rsp_fault,
   input  logic            flush,
   input  logic            ptbr_we,
   input  logic [PA_W-1:0] ptbr_wdata,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic            mem_req_write,
   output logic [PA_W-1:0] mem_req_addr,
   output logic [PTE_W-1:0] mem_req_wdata,
   input  logic            mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_rdata
);
   localparam int VPN_W = VA_W - PAGE_B;
   localparam int PPN_W = PA_W - PAGE_B;
   localparam int IW    = $clog2(ENTRIES);
   localparam int RSV_W = PTE_W - 2 - PPN_W;
   localparam int BIT_V = PTE_W - 1;
   localparam int BIT_D = PTE_W - 2;

   if (ENTRIES < 2) begin : g_bad_depth
      $error("xlat_tlb: ENTRIES must be at least 2");
   end
   if (PA_W <= PAGE_B || VA_W <= PAGE_B) begin : g_bad_addr
      $error("xlat_tlb: address widths must exceed the page offset");
   end
   if (RSV_W < 0) begin : g_bad_pte
      $error("xlat_tlb: entry too narrow for flags and page number");
   end
   if (PA_W < VPN_W + 2) begin : g_bad_tbl
      $error("xlat_tlb: table index does not fit the physical address");
   end

   walk_st_e         state_q;
   logic [VA_W-1:0]  va_q;
   logic             wr_q;
   logic             hitf_q;
   logic [PPN_W-1:0] ppn_q;
   logic [PA_W-1:0]  ptbr_q;
   logic [PA_W-1:0]  pte_addr_q;
   logic [PTE_W-1:0] wdata_q;
   logic             rsp_v_q, rsp_h_q, rsp_f_q;
   logic [PA_W-1:0]  rsp_pa_q;

   logic             accept;
   logic [VPN_W-1:0] lk_vpn;
   logic             lk_hit, lk_dirty, free_ok;
   logic [IW-1:0]    lk_idx, free_idx, lru_idx, victim;
   logic [PPN_W-1:0] lk_ppn;
   logic             fill_en, mark_en, touch_en;
   logic [IW-1:0]    touch_idx;
   logic [PPN_W-1:0] fetched_ppn;
   logic [PA_W-1:0]  pte_addr_d;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign lk_vpn    = req_vaddr[VA_W-1:PAGE_B];

   assign fetched_ppn = mem_rsp_rdata[PPN_W-1:0];
   assign victim      = free_ok ? free_idx : lru_idx;
   assign fill_en     = (state_q == ST_WAIT) && mem_rsp_valid && mem_rsp_rdata[BIT_V];
   assign mark_en     = accept && lk_hit && req_write && !lk_dirty;
   assign touch_en    = (accept && lk_hit) || fill_en;
   assign touch_idx   = accept ? lk_idx : victim;
   assign pte_addr_d  = ptbr_q + PA_W'({lk_vpn, 2'b00});

   xlat_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) cam_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (flush || ptbr_we),
      .lk_vpn     (lk_vpn),
      .lk_hit     (lk_hit),
      .lk_idx     (lk_idx),
      .lk_ppn     (lk_ppn),
      .lk_dirty   (lk_dirty),
      .fill_en    (fill_en),
      .fill_idx   (victim),
      .fill_vpn   (va_q[VA_W-1:PAGE_B]),
      .fill_ppn   (fetched_ppn),
      .fill_dirty (mem_rsp_rdata[BIT_D] | wr_q),
      .mark_en    (mark_en),
      .mark_idx   (lk_idx),
      .free_ok    (free_ok),
      .free_idx   (free_idx)
   );

   xlat_lru #(.N(ENTRIES)) lru_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (touch_en),
      .touch_idx  (touch_idx),
      .victim_idx (lru_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptbr_q <= '0;
      end else if (ptbr_we) begin
         ptbr_q <= ptbr_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         va_q       <= '0;
         wr_q       <= 1'b0;
         hitf_q     <= 1'b0;
         ppn_q      <= '0;
         pte_addr_q <= '0;
         wdata_q    <= '0;
         rsp_v_q    <= 1'b0;
         rsp_h_q    <= 1'b0;
         rsp_f_q    <= 1'b0;
         rsp_pa_q   <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  va_q       <= req_vaddr;
                  wr_q       <= req_write;
                  pte_addr_q <= pte_addr_d;
                  if (lk_hit) begin
                     ppn_q  <= lk_ppn;
                     hitf_q <= 1'b1;
                     if (req_write && !lk_dirty) begin
                        wdata_q <= {2'b11, {RSV_W{1'b0}}, lk_ppn};
                        state_q <= ST_WBACK;
                     end else begin
                        rsp_v_q  <= 1'b1;
                        rsp_h_q  <= 1'b1;
                        rsp_f_q  <= 1'b0;
                        rsp_pa_q <= {lk_ppn, req_vaddr[PAGE_B-1:0]};
                     end
                  end else begin
                     hitf_q  <= 1'b0;
                     state_q <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  ppn_q <= fetched_ppn;
                  if (!mem_rsp_rdata[BIT_V]) begin
                     rsp_v_q <= 1'b1;
                     rsp_h_q <= 1'b0;
                     rsp_f_q <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (wr_q && !mem_rsp_rdata[BIT_D]) begin
                     wdata_q <= {2'b11, {RSV_W{1'b0}}, fetched_ppn};
                     state_q <= ST_WBACK;
                  end else begin
                     rsp_v_q  <= 1'b1;
                     rsp_h_q  <= 1'b0;
                     rsp_f_q  <= 1'b0;
                     rsp_pa_q <= {fetched_ppn, va_q[PAGE_B-1:0]};
                     state_q  <= ST_IDLE;
                  end
               end
            end
            ST_WBACK: begin
               if (mem_req_ready) begin
                  rsp_v_q  <= 1'b1;
                  rsp_h_q  <= hitf_q;
                  rsp_f_q  <= 1'b0;
                  rsp_pa_q <= {ppn_q, va_q[PAGE_B-1:0]};
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (state_q == ST_FETCH) || (state_q == ST_WBACK);
   assign mem_req_write = (state_q == ST_WBACK);
   assign mem_req_addr  = pte_addr_q;
   assign mem_req_wdata = wdata_q;
   assign rsp_valid     = rsp_v_q;
   assign rsp_hit       = rsp_h_q;
   assign rsp_fault     = rsp_f_q;
   assign rsp_paddr     = rsp_pa_q;
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
   parameter int PA_W  = 30,
   parameter int PTE_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic             rsp_fault,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic             mem_req_write,
   input logic [PA_W-1:0]  mem_req_addr,
   input logic [PTE_W-1:0] mem_req_wdata
);
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R7

   AST_BUSY_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready); // R7

   AST_FAULT_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> !rsp_hit); // R4

   AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                           && $stable(mem_req_write)); // R2

   AST_WB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |-> mem_req_wdata[PTE_W-1] && mem_req_wdata[PTE_W-2]); // R5

   AST_NO_MEM_AT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready); // R1
endmodule

bind xlat_tlb xlat_tlb_chk #(.PA_W(PA_W), .PTE_W(PTE_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_hit       (rsp_hit),
   .rsp_fault     (rsp_fault),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_write (mem_req_write),
   .mem_req_addr  (mem_req_addr),
   .mem_req_wdata (mem_req_wdata)
);

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        rsp_valid;
   logic [29:0] rsp_paddr;
   logic        rsp_hit, rsp_fault;
   logic        flush = 1'b0;
   logic        ptbr_we = 1'b0;
   logic [29:0] ptbr_wdata = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic        mem_req_write;
   logic [29:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_rdata = '0;

   always #4 clk = ~clk;

   xlat_tlb dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
      .flush(flush), .ptbr_we(ptbr_we), .ptbr_wdata(ptbr_wdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
   );

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   int unsigned tid = 0;
   logic [29:0] base = '0;
   bit          dmem [256];
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   int unsigned cur_vpn = 0;

   bit          m_v [N];
   int unsigned m_vpn [N];
   bit          m_d [N];
   int unsigned m_st [N];
   int unsigned stamp = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [17:0] pte_ppn(input int unsigned v);
      return 18'((v * 37 + 11 + tid * 1000) & 32'h3FFFF);
   endfunction

   function automatic bit pte_present(input int unsigned v);
      return (v % 5) != 3;
   endfunction

   task automatic reset_dmem();
      for (int i = 0; i < 256; i++) dmem[i] = ((i % 7) == 0);
   endtask

   task automatic model_clear();
      for (int i = 0; i < N; i++) m_v[i] = 0;
   endtask

   // memory responder: reads answer two cycles after acceptance
   initial begin
      int pend = 0;
      int unsigned pv = 0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_rdata = {pte_present(pv), dmem[pv], 12'b0, pte_ppn(pv)};
            end
         end
         if (mem_req_valid) begin
            chk(mem_req_addr == base + 30'(cur_vpn * 4), "R2 entry address",
                64'(mem_req_addr), 64'(base + 30'(cur_vpn * 4)));
            if (mem_req_write) begin
               wr_cnt++;
               chk(mem_req_wdata == {2'b11, 12'b0, pte_ppn(cur_vpn)}, "R5 write-back data",
                   64'(mem_req_wdata), 64'({2'b11, 12'b0, pte_ppn(cur_vpn)}));
               dmem[cur_vpn] = 1'b1;
            end else begin
               rd_cnt++;
               pv = cur_vpn;
               pend = 2;
            end
         end
      end
   end

   task automatic do_req(input int unsigned vpn, input logic [11:0] off, input bit wr, input string ph);
      int  hi = -1;
      bit  e_hit, e_fault;
      int  e_rd, e_wr, cyc;
      logic [17:0] e_ppn;
      int  rd0, wr0;
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) hi = i;
      e_hit = (hi >= 0);
      e_fault = 0; e_rd = 0; e_wr = 0;
      e_ppn = pte_ppn(vpn);
      stamp++;
      if (e_hit) begin
         e_wr = (wr && !m_d[hi]) ? 1 : 0;
         m_st[hi] = stamp;
         if (wr) m_d[hi] = 1;
      end else begin
         e_rd = 1;
         if (!pte_present(vpn)) begin
            e_fault = 1;
         end else begin
            int vi = -1;
            for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vi = i;
            if (vi < 0) begin
               vi = 0;
               for (int i = 1; i < N; i++) if (m_st[i] < m_st[vi]) vi = i;
            end
            e_wr = (wr && !dmem[vpn]) ? 1 : 0;
            m_v[vi] = 1; m_vpn[vi] = vpn; m_st[vi] = stamp;
            m_d[vi] = dmem[vpn] | wr;
         end
      end
      rd0 = rd_cnt; wr0 = wr_cnt;
      cur_vpn = vpn;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = {20'(vpn), off}; req_write = wr;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      if (e_rd + e_wr > 0) chk(req_ready == 1'b0, {ph, " R7 busy during walk"}, 64'(req_ready), 0);
      while (!rsp_valid && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      chk(rsp_valid == 1'b1, {ph, " R7 response seen"}, 64'(rsp_valid), 1);
      chk(rsp_hit == e_hit, {ph, " R6 hit/miss"}, 64'(rsp_hit), 64'(e_hit));
      chk(rsp_fault == e_fault, {ph, " R4 fault flag"}, 64'(rsp_fault), 64'(e_fault));
      if (!e_fault)
         chk(rsp_paddr == {e_ppn, off}, {ph, e_hit ? " R1 hit address" : " R3 walked address"},
             64'(rsp_paddr), 64'({e_ppn, off}));
      chk(rd_cnt - rd0 == e_rd, {ph, " R2 entry reads"}, 64'(rd_cnt - rd0), 64'(e_rd));
      chk(wr_cnt - wr0 == e_wr, {ph, " R5 entry writes"}, 64'(wr_cnt - wr0), 64'(e_wr));
      if (e_hit && e_wr == 0) chk(cyc == 1, {ph, " R1 hit latency"}, 64'(cyc), 1);
      @(negedge clk);
      chk(rsp_valid == 1'b0, {ph, " R7 single pulse"}, 64'(rsp_valid), 0);
   endtask

   task automatic load_base(input logic [29:0] b);
      @(negedge clk);
      ptbr_we = 1'b1; ptbr_wdata = b;
      @(negedge clk);
      ptbr_we = 1'b0;
      base = b;
      tid++;
      reset_dmem();
      model_clear();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         nchk++;
         $display("FAIL R7 watchdog expired act=%0d exp=%0d", 150000, 0);
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] lcg = 32'h1234_5678;
      reset_dmem();
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 1);
      chk(rsp_valid == 1'b0, "R10 no response after reset", 64'(rsp_valid), 0);
      chk(mem_req_valid == 1'b0, "R10 no memory request after reset", 64'(mem_req_valid), 0);
      do_req(5, 12'h0AB, 0, "R10 empty store");
      // R9 base load flushes and relocates the table
      tid = 0;
      load_base(30'h0010_0000);
      // R6 ascending fill past capacity, with faults (R4)
      for (int v = 0; v < 12; v++) do_req(v, 12'(v * 13), 0, "fillA");
      do_req(3, 12'h004, 0, "R4 refault");
      for (int v = 0; v < 12; v++) do_req(v, 12'(v * 7 + 1), 0, "passB");
      // R5 writes over more pages than slots
      for (int v = 0; v < 16; v++) do_req(v, 12'hFFF, 1, "R5 writes");
      for (int v = 0; v < 4; v++) do_req(v + 12, 12'h100, 1, "R5 rewrite");
      // mixed pseudo-random traffic
      for (int k = 0; k < 400; k++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         do_req(int'(lcg[19:16]), lcg[11:0], lcg[24], "mix");
      end
      // R8 flush
      for (int v = 0; v < 4; v++) do_req(v, 12'h010, 0, "preflush");
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      model_clear();
      for (int v = 0; v < 4; v++) do_req(v, 12'h020, 0, "R8 after flush");
      // R9 base change with new table contents
      load_base(30'h0020_0000);
      for (int v = 0; v < 10; v++) do_req(v, 12'h030, v[0], "R9 new base");
      for (int k = 0; k < 100; k++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         do_req(int'(lcg[19:16]) + 16, lcg[11:0], lcg[25], "mix2");
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule